// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block moves bytes between a parallel register port and a pair of asynchronous serial lines. A byte written to the buffer window waits in a transmit queue until the serial shifter takes it and sends it as one start bit, eight data bits (least significant first) and one stop bit. Incoming frames on the receive line are centre-sampled from a 16x oversampling tick, and each completed byte is placed in a receive queue that the host drains by reading the same window.

The port has two addresses. Address 1 is the control word. Address 0 is a shared window: while the divisor-select flag is clear it reads the oldest received byte and writes the transmit queue; while that flag is set it reads and writes the 16-bit baud divisor. The control word also holds a line-break flag, a queue-mode flag (16-deep queues or single-byte buffering) and two self-clearing flush commands, one per direction. The host watches four flags: transmit queue empty, transmit queue full, receive data waiting and receive overrun.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset txd is 1, tx_empty is 1, tx_full, rx_avail and rx_overrun are 0, the control word reads 0 and the divisor reads 0.
- R2: The oversampling tick fires once every divisor+1 clocks and each serial bit lasts 16 ticks; a frame is a 0 start bit, eight data bits least significant first, and a 1 stop bit, with the line idle at 1.
- R3: With control bit 8 set, the transmit queue holds 16 bytes besides the one in the shifter; tx_full rises when it holds 16, and writes while full are dropped.
- R4: With control bit 8 clear, each direction holds one byte, so a third quick write after an idle start is dropped and only two frames go out.
- R5: Any write that changes control bit 8 empties both queues at once; a frame already in the transmit shifter still goes out.
- R6: While control bit 6 is 1, txd is held at 0, yet the transmit shifter keeps taking and sending queued bytes, so those bytes never appear on the line afterwards.
- R7: While control bit 7 is 1, address 0 reads and writes the divisor instead of the data queues; writes there place nothing in the transmit queue.
- R8: A valid frame on rxd places its byte in the receive queue, raises rx_avail, and a read of address 0 with control bit 7 clear returns that byte in bits 7:0 and removes it.
- R9: A byte that completes while the receive queue is full is discarded and rx_overrun becomes 1 and stays 1 until a receive flush; the stored bytes are kept.
- R10: Writing 1 to control bit 9 empties the receive queue and clears rx_overrun; a frame being assembled at that moment is stored when it completes.
- R11: Writing 1 to control bit 10 empties the transmit queue; the frame already in the shifter completes normally.
- R12: Control bits 9 and 10 are commands that always read back as 0; bits 6, 7 and 8 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | 0 selects the shared buffer/divisor window, 1 the control word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; pops the receive queue when reading the data window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_full | output | 1 | Transmit queue is at its capacity |
| rx_avail | output | 1 | At least one received byte is waiting |
| rx_overrun | output | 1 | A received byte was lost because the queue was full |

## Verification
The hardest situation to reach is a receive flush landing while a frame is half assembled, because the outcome depends on the flush striking between the start bit and the stop bit. The bench forks a serial sender and, on a parallel branch, counts five bit periods before issuing the flush, then confirms the queue shrank to nothing and afterwards holds only the late byte. The transmit break and flush cases are reached the same way, by a background line decoder that runs alongside writes made faster than frames drain.

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        tx_empty,
  output logic        tx_full,
  output logic        rx_avail,
  output logic        rx_overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic             brk, dlab, fen;
  logic [DIV_W-1:0] div, bcnt;

  wire ctrl_wr   = wr_en & addr;
  wire buf_wr    = wr_en & ~addr & ~dlab;
  wire div_wr    = wr_en & ~addr & dlab;
  wire buf_rd    = rd_en & ~addr & ~dlab;
  wire mode_flip = ctrl_wr & (wdata[8] != fen);
  wire rx_flush  = mode_flip | (ctrl_wr & wdata[9]);
  wire tx_flush  = mode_flip | (ctrl_wr & wdata[10]);
  wire [CW-1:0] cap = fen ? CW'(DEPTH) : CW'(1);
  wire tick = (bcnt >= div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brk <= 1'b0; dlab <= 1'b0; fen <= 1'b0; div <= '0;
    end else begin
      if (ctrl_wr) begin
        brk  <= wdata[6];
        dlab <= wdata[7];
        fen  <= wdata[8];
      end
      if (div_wr) div <= wdata[DIV_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? '0 : bcnt + 1'b1;

  // transmit queue
  logic [7:0]    tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [CW-1:0] tcnt;
  logic          tx_busy;
  logic [9:0]    tsh;
  logic [3:0]    tos, tbits;

  assign tx_empty = (tcnt == '0);
  assign tx_full  = (tcnt >= cap);
  wire tpush = buf_wr & ~tx_full;
  wire tpop  = ~tx_busy & ~tx_empty & ~tx_flush;

  always_ff @(posedge clk)
    if (tpush) tmem[twp] <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else if (tx_flush) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (tpush) twp <= twp + 1'b1;
      if (tpop)  trp <= trp + 1'b1;
      tcnt <= tcnt + CW'(tpush) - CW'(tpop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tsh <= '1; tos <= '0; tbits <= '0;
    end else if (tpop) begin
      tx_busy <= 1'b1;
      tsh     <= {1'b1, tmem[trp], 1'b0};
      tos     <= '0;
      tbits   <= '0;
    end else if (tx_busy && tick) begin
      tos <= tos + 4'd1;
      if (tos == 4'd15) begin
        tsh   <= {1'b1, tsh[9:1]};
        tbits <= tbits + 4'd1;
        if (tbits == 4'd9) tx_busy <= 1'b0;
      end
    end

  wire tx_line = tx_busy ? tsh[0] : 1'b1;
  assign txd = tx_line & ~brk;

  // receive engine
  logic [1:0] rsy;
  logic       rx_busy, rvalid;
  logic [3:0] ros, rbits;
  logic [7:0] rsh;
  wire rin = rsy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsy <= 2'b11;
    else        rsy <= {rsy[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rvalid <= 1'b0; ros <= '0; rbits <= '0; rsh <= '0;
    end else begin
      rvalid <= 1'b0;
      if (tick) begin
        if (!rx_busy) begin
          if (!rin) begin
            rx_busy <= 1'b1; ros <= '0; rbits <= '0;
          end
        end else begin
          ros <= ros + 4'd1;
          if (ros == 4'd7) begin
            if (rbits == 4'd0) begin
              if (rin) rx_busy <= 1'b0;
            end else if (rbits == 4'd9) begin
              rx_busy <= 1'b0;
              rvalid  <= rin;
            end else begin
              rsh <= {rin, rsh[7:1]};
            end
          end
          if (ros == 4'd15) rbits <= rbits + 4'd1;
        end
      end
    end

  // receive queue
  logic [7:0]    rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;
  logic          ovr;

  wire rx_room = rx_flush | (rcnt < cap);
  wire rpush   = rvalid & rx_room;
  wire rpop    = buf_rd & (rcnt != '0) & ~rx_flush;
  wire [AW-1:0] rwidx = rx_flush ? '0 : rwp;

  always_ff @(posedge clk)
    if (rpush) rmem[rwidx] <= rsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0; ovr <= 1'b0;
    end else if (rx_flush) begin
      rwp  <= rpush ? AW'(1) : '0;
      rrp  <= '0;
      rcnt <= CW'(rpush);
      ovr  <= 1'b0;
    end else begin
      if (rpush) rwp <= rwp + 1'b1;
      if (rpop)  rrp <= rrp + 1'b1;
      rcnt <= rcnt + CW'(rpush) - CW'(rpop);
      if (rvalid && !rx_room) ovr <= 1'b1;
    end

  assign rx_avail   = (rcnt != '0);
  assign rx_overrun = ovr;
  assign rdata = addr ? {5'b0, fen, dlab, brk, 6'b0}
               : dlab ? 16'(div) : {8'b0, rmem[rrp]};
endmodule

// File: rtl/uart_fifo_core_chk.sv
module uart_fifo_core_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fen,
  input logic          tx_busy,
  input logic          tx_line,
  input logic          tx_empty,
  input logic          tx_full,
  input logic          rx_avail,
  input logic          rx_overrun,
  input logic [CW-1:0] tcnt,
  input logic [CW-1:0] rcnt
);
  a_r3_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt <= (fen ? CW'(DEPTH) : CW'(1))) && (rcnt <= (fen ? CW'(DEPTH) : CW'(1))));

  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_empty);

  a_r5_flip_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (fen != $past(fen)) |-> tx_empty);

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  a_r9_overrun_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_avail));
endmodule

bind uart_fifo_core uart_fifo_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fen(fen), .tx_busy(tx_busy), .tx_line(tx_line),
  .tx_empty(tx_empty), .tx_full(tx_full), .rx_avail(rx_avail),
  .rx_overrun(rx_overrun), .tcnt(tcnt), .rcnt(rcnt)
);

// File: tb/uart_fifo_core_bench.sv
module uart_fifo_core_bench;
  logic clk = 0, rst_n = 0, addr = 0, wr_en = 0, rd_en = 0, rxd = 1;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic txd, tx_empty, tx_full, rx_avail, rx_overrun;

  uart_fifo_core u_uart_fifo_core (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, bp = 16;
  logic mon_en = 1;
  logic cur_fen = 0;
  logic [7:0] txq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ctrl(input logic b, input logic dl, input logic f, input logic rc, input logic tc);
    wr(1'b1, {5'b0, tc, rc, f, dl, b, 6'b0});
    cur_fen = f;
  endtask

  task automatic set_div(input int d);
    ctrl(0, 1, cur_fen, 0, 0);
    wr(1'b0, 16'(d));
    ctrl(0, 0, cur_fen, 0, 0);
    bp = 16 * (d + 1);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rxd = 0; repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bp) @(negedge clk); end
    rxd = 1; repeat (bp) @(negedge clk);
  endtask

  task automatic idle(input int frames);
    repeat (frames * 10 * bp + 40) @(negedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    if (mon_en && txd === 1'b0) begin
      logic [7:0] b;
      repeat (bp / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (bp) @(negedge clk); b[i] = txd; end
      repeat (bp) @(negedge clk);
      if (mon_en) txq.push_back(b);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int lo, errs;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 txd", txd, 1); chk("R1 tx_empty", tx_empty, 1); chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_avail", rx_avail, 0); chk("R1 rx_overrun", rx_overrun, 0);
    rd(1, d); chk("R1 ctrl", d, 0);
    ctrl(0, 1, 0, 0, 0); rd(0, d); chk("R1 divisor", d, 0);
    // R7
    wr(0, 16'h0003); rd(0, d); chk("R7 divisor readback", d, 3);
    chk("R7 no tx push", tx_empty, 1);
    ctrl(0, 0, 0, 0, 0);
    // R2 sweep over divisor values
    for (int dv = 0; dv < 4; dv++) begin
      set_div(dv);
      txq.delete();
      wr(0, 16'h0000);
      while (txd !== 1'b0) @(negedge clk);
      lo = 0;
      while (txd === 1'b0) begin lo++; @(negedge clk); end
      total++;
      if (lo > 9 * bp || lo < 9 * bp - dv - 1) begin
        bad++; $display("FAIL R2 low time actual=%0d expected=%0d", lo, 9 * bp);
      end
      idle(1);
      txq.delete();
      wr(0, 16'((dv * 8'h37 + 8'h5A) & 8'hFF));
      idle(2);
      chk("R2 frame count", txq.size(), 1);
      if (txq.size() > 0) chk("R2 frame data", txq[0], (dv * 8'h37 + 8'h5A) & 8'hFF);
    end
    set_div(0);
    // R8 receive sweep, single-byte mode
    for (int i = 0; i < 8; i++) begin
      send(8'((i * 37 + 11) & 8'hFF));
      chk("R8 rx_avail set", rx_avail, 1);
      rd(0, d); chk("R8 rx data", d, (i * 37 + 11) & 8'hFF);
      chk("R8 rx_avail clear", rx_avail, 0);
    end
    // R4 single-byte transmit
    txq.delete();
    wr(0, 16'h00A1); wr(0, 16'h00B2); wr(0, 16'h00C3);
    chk("R4 tx_full", tx_full, 1);
    idle(4);
    chk("R4 frames", txq.size(), 2);
    if (txq.size() == 2) begin chk("R4 first", txq[0], 8'hA1); chk("R4 second", txq[1], 8'hB2); end
    // R3 deep queue
    ctrl(0, 0, 1, 0, 0);
    txq.delete();
    for (int i = 0; i < 18; i++) wr(0, 16'(8'h40 + i));
    chk("R3 tx_full", tx_full, 1);
    idle(19);
    chk("R3 frames", txq.size(), 17);
    errs = 0;
    for (int i = 0; i < txq.size(); i++) if (txq[i] !== 8'(8'h40 + i)) errs++;
    chk("R3 order", errs, 0);
    chk("R3 drained", tx_empty, 1);
    // R6 break
    mon_en = 0;
    ctrl(1, 0, 1, 0, 0);
    wr(0, 16'h00A5);
    errs = 0;
    repeat (400) begin @(negedge clk); if (txd !== 1'b0) errs++; end
    chk("R6 txd held low", errs, 0);
    chk("R6 byte consumed", tx_empty, 1);
    ctrl(0, 0, 1, 0, 0);
    txq.delete(); mon_en = 1;
    idle(2);
    chk("R6 nothing after break", txq.size(), 0);
    chk("R6 line idle", txd, 1);
    // R11 transmit flush
    txq.delete();
    for (int i = 0; i < 4; i++) wr(0, 16'(8'h11 + i));
    ctrl(0, 0, 1, 0, 1);
    chk("R11 tx_empty", tx_empty, 1);
    idle(5);
    chk("R11 frames", txq.size(), 1);
    if (txq.size() > 0) chk("R11 in-flight byte", txq[0], 8'h11);
    // R5 mode change
    send(8'h21); send(8'h22);
    chk("R5 rx filled", rx_avail, 1);
    txq.delete();
    for (int i = 0; i < 3; i++) wr(0, 16'(8'h61 + i));
    ctrl(0, 0, 0, 0, 0);
    chk("R5 tx flushed", tx_empty, 1);
    chk("R5 rx flushed", rx_avail, 0);
    idle(4);
    chk("R5 frames", txq.size(), 1);
    if (txq.size() > 0) chk("R5 in-flight byte", txq[0], 8'h61);
    ctrl(0, 0, 1, 0, 0);
    // R10 receive flush during a frame
    send(8'h01); send(8'h02);
    fork
      send(8'h3C);
      begin
        repeat (5 * bp) @(negedge clk);
        ctrl(0, 0, 1, 1, 0);
        chk("R10 flushed", rx_avail, 0);
      end
    join
    chk("R10 late byte stored", rx_avail, 1);
    rd(0, d); chk("R10 late byte", d, 16'h003C);
    chk("R10 single entry", rx_avail, 0);
    // R9 overrun
    for (int i = 0; i < 17; i++) send(8'((i * 13 + 7) & 8'hFF));
    chk("R9 overrun", rx_overrun, 1);
    errs = 0;
    for (int i = 0; i < 16; i++) begin rd(0, d); if (d !== 16'((i * 13 + 7) & 8'hFF)) errs++; end
    chk("R9 stored bytes", errs, 0);
    chk("R9 drained", rx_avail, 0);
    chk("R9 sticky", rx_overrun, 1);
    ctrl(0, 0, 1, 1, 0);
    chk("R9 cleared by flush", rx_overrun, 0);
    // R12 command bits read back as 0
    ctrl(1, 1, 1, 1, 1);
    rd(1, d); chk("R12 readback", d, 16'h01C0);
    ctrl(0, 0, 1, 0, 0);
    rd(1, d); chk("R12 readback low", d, 16'h0100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule